// File: doc/BRIEF.md
# Temperature Limit and Alarm Logic

This block watches two signed 8-bit temperature readings, one from an on-die sensor and one from a remote diode. Each time a new pair of readings is strobed in, it compares them against programmable thresholds. It keeps a set of status flags and drives four outputs: an active-low alert request, an active-low over-temperature line, an active-low thermal-throttle line, and a request to run the cooling fan at full speed.

The flags behave in three ways. Range and passive-cooling flags are sticky and clear when status is read. Throttle flags clear on a read and do not set again until the temperature has dropped by a hysteresis margin. Critical flags follow the latest sample, and the remote-sensor fault flag stays latched until reset. A run input gates monitoring, and the first sample after run rises only primes the logic.

Top module: `temp_alarm`

## Requirements
- R1: Per channel, the high flag sets when the temperature is >= the high limit, and the low flag sets when it is <= the low limit. The channel's range flag is their OR and drives the alert only when that channel's range enable is set. Status bits: [0] local high, [1] local low, [2] local range, [3] remote high, [4] remote low, [5] remote range.
- R2: A temperature >= its critical limit sets critical bit [6] (local) or [7] (remote) on that sample. The bit clears on a later sample below the limit, and a status read does not clear it. Any critical bit drives ovr_n low and alert_n low whatever the enables are.
- R3: thr_n goes low when a channel is >= its throttle limit. It stays low until a sample of that channel is <= limit − 5.
- R4: A throttle flag ([8] local, [9] remote) sets on a sample >= the limit. A status read clears it. It does not set again until a sample <= limit − 5 has been seen. While set, it alerts if ie_thr is set.
- R5: full_speed is high when thr_fan_en is set and a throttle flag is set, or when external flag [12] is set. Flag [12] sets in any cycle where ext_thr_n is low, and clears on a read once the input is high.
- R6: A sample taken with rem_fault high uses −128 (0x80) as the remote reading, which is shown on rem_rd. The same sample sets fault bit [11]. Bit [11] holds until reset, keeps ovr_n low, and alerts only when ie_fault is set.
- R7: Passive flag [10] sets when the control temperature is <= psv_lim. The control temperature is the remote reading when ctl_sel=0 and the larger of the two readings when ctl_sel=1. The flag alerts if ie_psv is set.
- R8: While run is low, and on the first strobe after run rises, no flag changes.
- R9: All comparisons treat readings and limits as signed two's complement.
- R10: Between strobes, flags change only by a read. A read clears bits [0..5], [8..10]. When a read and a strobe land in the same cycle, the strobe's new conditions win.
- R11: After reset all flags are 0, alert_n, ovr_n and thr_n are 1, full_speed is 0, and rem_rd is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Monitoring enable |
| smp_vld | input | 1 | New sample strobe |
| loc_temp | input | 8 | Local reading, signed |
| rem_temp | input | 8 | Remote reading, signed |
| rem_fault | input | 1 | Remote sensor fault with this sample |
| stat_rd | input | 1 | Status read strobe |
| ext_thr_n | input | 1 | External throttle request, active low |
| loc_hi | input | 8 | Local high limit |
| loc_lo | input | 8 | Local low limit |
| rem_hi | input | 8 | Remote high limit |
| rem_lo | input | 8 | Remote low limit |
| loc_crit | input | 8 | Local critical limit |
| rem_crit | input | 8 | Remote critical limit |
| loc_thr | input | 8 | Local throttle limit |
| rem_thr | input | 8 | Remote throttle limit |
| psv_lim | input | 8 | Passive cooling limit |
| ctl_sel | input | 1 | Control temperature: 0 remote, 1 max of both |
| ie_loc | input | 1 | Local range alert enable |
| ie_rem | input | 1 | Remote range alert enable |
| ie_psv | input | 1 | Passive alert enable |
| ie_thr | input | 1 | Throttle alert enable |
| ie_fault | input | 1 | Fault alert enable |
| thr_fan_en | input | 1 | Throttle flags force full fan speed |
| status | output | 13 | Flag vector, bit map in R1 to R7 |
| alert_n | output | 1 | Alert request, active low |
| ovr_n | output | 1 | Over-temperature, active low |
| thr_n | output | 1 | Throttle output, active low |
| full_speed | output | 1 | Full fan speed request |
| rem_rd | output | 8 | Last effective remote reading |

## Verification
Every flag and rem_rd is registered at the clock edge that takes a strobe or a read. They are therefore due one cycle later. The bench drives each strobe on a falling edge for one cycle and compares at the next falling edge. Flag [12] follows ext_thr_n by one edge in the same way. alert_n, ovr_n, thr_n and full_speed decode the registered flags and the enables without any further register. Their checks therefore sit in the same sample slot as the flags. After an enable is changed, the bench waits a short settling delay before comparing.

// File: rtl/temp_alarm.sv
module temp_alarm #(
  parameter int TW   = 8,
  parameter int HYST = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 smp_vld,
  input  logic signed [TW-1:0] loc_temp,
  input  logic signed [TW-1:0] rem_temp,
  input  logic                 rem_fault,
  input  logic                 stat_rd,
  input  logic                 ext_thr_n,
  input  logic signed [TW-1:0] loc_hi,
  input  logic signed [TW-1:0] loc_lo,
  input  logic signed [TW-1:0] rem_hi,
  input  logic signed [TW-1:0] rem_lo,
  input  logic signed [TW-1:0] loc_crit,
  input  logic signed [TW-1:0] rem_crit,
  input  logic signed [TW-1:0] loc_thr,
  input  logic signed [TW-1:0] rem_thr,
  input  logic signed [TW-1:0] psv_lim,
  input  logic                 ctl_sel,
  input  logic                 ie_loc,
  input  logic                 ie_rem,
  input  logic                 ie_psv,
  input  logic                 ie_thr,
  input  logic                 ie_fault,
  input  logic                 thr_fan_en,
  output logic [12:0]          status,
  output logic                 alert_n,
  output logic                 ovr_n,
  output logic                 thr_n,
  output logic                 full_speed,
  output logic [TW-1:0]        rem_rd
);
  localparam logic signed [TW:0]   HY     = (TW+1)'(HYST);
  localparam logic signed [TW-1:0] NEG_FS = {1'b1, {(TW-1){1'b0}}};

  function automatic logic released(input logic signed [TW-1:0] t,
                                    input logic signed [TW-1:0] lim);
    logic signed [TW:0] te, le;
    te = {t[TW-1], t};
    le = {lim[TW-1], lim};
    return te <= (le - HY);
  endfunction

  logic primed;
  logic detect;
  assign detect = smp_vld & run & primed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      primed <= 1'b0;
    else if (!run)   primed <= 1'b0;
    else if (smp_vld) primed <= 1'b1;

  logic signed [TW-1:0] rem_eff, ctl_t;
  assign rem_eff = rem_fault ? NEG_FS : rem_temp;
  assign ctl_t   = (ctl_sel && (loc_temp > rem_eff)) ? loc_temp : rem_eff;

  logic [4:0] stk, stk_c;
  assign stk_c = {ctl_t <= psv_lim, rem_eff <= rem_lo, rem_eff >= rem_hi,
                  loc_temp <= loc_lo, loc_temp >= loc_hi};

  logic [1:0] crit_c, thr_ge, thr_rel;
  assign crit_c  = {rem_eff >= rem_crit, loc_temp >= loc_crit};
  assign thr_ge  = {rem_eff >= rem_thr,  loc_temp >= loc_thr};
  assign thr_rel = {released(rem_eff, rem_thr), released(loc_temp, loc_thr)};

  logic [1:0] crit, thr_on, thr_flg, armed;
  logic [1:0] flg_n, arm_n;
  logic       fault, ext_flg;

  always_comb begin
    arm_n = stat_rd ? (armed & ~thr_flg) : armed;
    flg_n = stat_rd ? 2'b00 : thr_flg;
    if (detect) begin
      arm_n = arm_n | thr_rel;
      flg_n = flg_n | (thr_ge & arm_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stk     <= '0;
      crit    <= '0;
      thr_on  <= '0;
      thr_flg <= '0;
      armed   <= '1;
      fault   <= 1'b0;
      ext_flg <= 1'b0;
      rem_rd  <= NEG_FS;
    end else begin
      stk     <= (detect ? stk_c : 5'b0) | (stat_rd ? 5'b0 : stk);
      thr_flg <= flg_n;
      armed   <= arm_n;
      if (detect) begin
        crit   <= crit_c;
        thr_on <= thr_ge | (thr_on & ~thr_rel);
        rem_rd <= rem_eff;
        if (rem_fault) fault <= 1'b1;
      end
      if (!ext_thr_n)   ext_flg <= 1'b1;
      else if (stat_rd) ext_flg <= 1'b0;
    end

  logic loc_rng, rem_rng;
  assign loc_rng = stk[0] | stk[1];
  assign rem_rng = stk[2] | stk[3];

  assign status = {ext_flg, fault, stk[4], thr_flg, crit,
                   rem_rng, stk[3], stk[2], loc_rng, stk[1], stk[0]};

  assign ovr_n      = ~(|crit | fault);
  assign thr_n      = ~|thr_on;
  assign full_speed = ext_flg | (thr_fan_en & |thr_flg);
  assign alert_n    = ~((loc_rng & ie_loc) | (rem_rng & ie_rem) | (stk[4] & ie_psv) |
                        (|thr_flg & ie_thr) | (fault & ie_fault) | |crit);
endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_vld,
  input logic        stat_rd,
  input logic        ext_thr_n,
  input logic [12:0] status,
  input logic        alert_n,
  input logic        ovr_n,
  input logic        full_speed
);
  AST_CRIT_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] | status[7]) |-> !ovr_n); // R2
  AST_CRIT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] | status[7]) |-> !alert_n); // R2
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    status[11] |=> status[11]); // R6
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !stat_rd) |=> $stable(status[11:0])); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !smp_vld) |=> (status[5:0] == 6'b0 && status[10:8] == 3'b0)); // R10
  AST_EXT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_thr_n |=> full_speed); // R5
endmodule

bind temp_alarm temp_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .stat_rd(stat_rd),
  .ext_thr_n(ext_thr_n), .status(status), .alert_n(alert_n),
  .ovr_n(ovr_n), .full_speed(full_speed)
);

// File: tb/temp_alarm_tb.sv
module temp_alarm_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, run, smp_vld, rem_fault, stat_rd, ext_thr_n;
  logic signed [7:0] loc_temp, rem_temp;
  logic signed [7:0] loc_hi, loc_lo, rem_hi, rem_lo, loc_crit, rem_crit, loc_thr, rem_thr, psv_lim;
  logic ctl_sel, ie_loc, ie_rem, ie_psv, ie_thr, ie_fault, thr_fan_en;
  logic [12:0] status;
  logic alert_n, ovr_n, thr_n, full_speed;
  logic [7:0] rem_rd;

  temp_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .smp_vld(smp_vld),
    .loc_temp(loc_temp), .rem_temp(rem_temp), .rem_fault(rem_fault),
    .stat_rd(stat_rd), .ext_thr_n(ext_thr_n),
    .loc_hi(loc_hi), .loc_lo(loc_lo), .rem_hi(rem_hi), .rem_lo(rem_lo),
    .loc_crit(loc_crit), .rem_crit(rem_crit), .loc_thr(loc_thr), .rem_thr(rem_thr),
    .psv_lim(psv_lim), .ctl_sel(ctl_sel), .ie_loc(ie_loc), .ie_rem(ie_rem),
    .ie_psv(ie_psv), .ie_thr(ie_thr), .ie_fault(ie_fault), .thr_fan_en(thr_fan_en),
    .status(status), .alert_n(alert_n), .ovr_n(ovr_n), .thr_n(thr_n),
    .full_speed(full_speed), .rem_rd(rem_rd)
  );

  int total = 0;
  int bad = 0;

  // {loc, rem, status, alert_n, ovr_n, thr_n, full_speed}; a read precedes each strobe
  localparam logic [32:0] VEC [12] = '{
    {8'd25,  8'd50,  13'h000, 4'b1110},
    {8'd60,  8'd0,   13'h435, 4'b0110},
    {8'hF6,  8'hFF,  13'h436, 4'b0110},
    {8'd59,  8'd1,   13'h400, 4'b0110},
    {8'd70,  8'd50,  13'h105, 4'b0101},
    {8'd66,  8'd50,  13'h005, 4'b0100},
    {8'd72,  8'd50,  13'h005, 4'b0100},
    {8'd65,  8'd50,  13'h005, 4'b0110},
    {8'd70,  8'd50,  13'h105, 4'b0101},
    {8'd20,  8'd95,  13'h228, 4'b0101},
    {8'd90,  8'd100, 13'h1ED, 4'b0001},
    {8'd20,  8'd20,  13'h400, 4'b0110}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic chk_all(input string what, input logic [12:0] st, input logic [3:0] o);
    chk({what, " status"}, 32'(status), 32'(st));
    chk({what, " outputs"}, 32'({alert_n, ovr_n, thr_n, full_speed}), 32'(o));
  endtask

  task automatic strobe(input logic [7:0] l, input logic [7:0] r, input logic rd);
    @(negedge clk);
    loc_temp = l; rem_temp = r; smp_vld = 1'b1; stat_rd = rd;
    @(negedge clk);
    smp_vld = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; run = 0; smp_vld = 0; rem_fault = 0; stat_rd = 0; ext_thr_n = 1;
    loc_temp = 0; rem_temp = 0;
    loc_hi = 60; loc_lo = -10; rem_hi = 80; rem_lo = 0;
    loc_crit = 90; rem_crit = 100; loc_thr = 70; rem_thr = 85; psv_lim = 30;
    ctl_sel = 0; ie_loc = 1; ie_rem = 1; ie_psv = 1; ie_thr = 1; ie_fault = 1; thr_fan_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R11 reset", 13'h000, 4'b1110);
    chk("R11 reset rem_rd", 32'(rem_rd), 32'h80);

    run = 1;
    strobe(8'd100, 8'd50, 1'b0);
    chk_all("R8 priming strobe ignored", 13'h000, 4'b1110);

    for (int i = 0; i < 12; i++) begin
      rd_pulse();
      strobe(VEC[i][32:25], VEC[i][24:17], 1'b0);
      chk_all($sformatf("table row %0d R1 R2 R3 R4 R5 R7 R9", i), VEC[i][16:4], VEC[i][3:0]);
    end

    rd_pulse();
    strobe(8'd60, 8'd50, 1'b0);
    chk_all("R10 set", 13'h005, 4'b0110);
    strobe(8'd25, 8'd50, 1'b0);
    chk_all("R10 sticky without read", 13'h005, 4'b0110);
    strobe(8'd25, 8'd50, 1'b1);
    chk_all("R10 read with clear sample", 13'h000, 4'b1110);
    strobe(8'd60, 8'd50, 1'b1);
    chk_all("R10 read with set sample", 13'h005, 4'b0110);

    rd_pulse();
    strobe(8'd40, 8'd20, 1'b0);
    chk_all("R7 remote control temp", 13'h400, 4'b0110);
    rd_pulse();
    ctl_sel = 1;
    strobe(8'd40, 8'd20, 1'b0);
    chk_all("R7 max control temp above", 13'h000, 4'b1110);
    rd_pulse();
    strobe(8'd30, 8'd10, 1'b0);
    chk_all("R7 max control temp at limit", 13'h400, 4'b0110);
    ctl_sel = 0;

    thr_fan_en = 0;
    @(negedge clk); ext_thr_n = 0;
    @(negedge clk); ext_thr_n = 1;
    chk("R5 ext flag", 32'(status[12]), 32'h1);
    chk("R5 ext forces full speed", 32'(full_speed), 32'h1);
    rd_pulse();
    chk_all("R5 ext cleared by read", 13'h000, 4'b1110);
    rd_pulse();
    strobe(8'd70, 8'd50, 1'b0);
    chk_all("R5 R4 throttle without fan enable", 13'h105, 4'b0100);
    rd_pulse();
    strobe(8'd20, 8'd50, 1'b0);
    chk_all("R3 release", 13'h000, 4'b1110);
    thr_fan_en = 1;

    rd_pulse();
    rem_fault = 1;
    strobe(8'd20, 8'd50, 1'b0);
    rem_fault = 0;
    chk_all("R6 fault sample", 13'hC30, 4'b0010);
    chk("R6 faulted reading", 32'(rem_rd), 32'h80);
    rd_pulse();
    strobe(8'd20, 8'd50, 1'b0);
    chk_all("R6 fault latched", 13'h800, 4'b0010);
    chk("R6 reading after fault", 32'(rem_rd), 32'h32);
    @(negedge clk); ie_fault = 0;
    #1;
    chk("R6 fault alert masked", 32'(alert_n), 32'h1);
    ie_fault = 1;

    run = 0;
    strobe(8'd100, 8'd50, 1'b0);
    chk_all("R8 run low ignored", 13'h800, 4'b0010);
    run = 1;
    strobe(8'd100, 8'd50, 1'b0);
    chk_all("R8 first strobe after run ignored", 13'h800, 4'b0010);
    strobe(8'd100, 8'd50, 1'b0);
    chk_all("R8 R2 detection resumes", 13'h945, 4'b0001);

    finish_run();
  end
endmodule